// File: doc/BRIEF.md
# Two-Pin Shared I/O Port

This block is a two-pin general-purpose port shared by a microcontroller bus and an on-chip programmable-logic fabric. The microcontroller sees three byte-wide registers: a live pin-level view, an output data register and a direction register. In each byte only two bit positions are backed by storage. The two pins occupy bit 1 (pin A) and bit 2 (pin B). Every other bit reads as zero and ignores writes. The port has no address-out function, so it has no control register.

Each pin has an output multiplexer. A static mode bit chooses whether the pin is driven from the microcontroller's data register or from a chip-select strobe that the fabric generates. A second static bit chooses the source of the output-driver enable: the direction register or a fabric product term. Pin levels pass to the fabric combinationally, with no input register. Pin A can also serve as the fabric's clock source. Pin B can act as an active-high chip-select input that shuts off the on-chip flash, SRAM and control-register space. Slew rate is a configuration bit that is only passed on to the pad.

Top module: `dpio_port`

## Requirements
- R1: In the cycle after reset, the output data register and the direction register are both zero. With the enable taken from the direction register, both pin drivers are off (both pins are inputs).
- R2: A write to address 1 (output data) stores write-data bits 2 and 1 as the values for pin B and pin A. A read of address 1 returns them in bits 2 and 1, with zeros in bits 7..3 and bit 0.
- R3: A write to address 2 (direction; 1 = output, 0 = input) stores bits 2 and 1 for pin B and pin A. A read of address 2 returns them in the same positions, with zeros elsewhere.
- R4: A read of address 0 returns the live levels of pin B and pin A in bits 2 and 1, with zeros elsewhere. A read of address 3 returns all zeros.
- R5: When a pin's mode bit is 0, the pin output equals its output data register bit. When the mode bit is 1, the pin output equals its fabric chip-select strobe.
- R6: When a pin's enable-source bit is 0, the pin's driver enable equals its direction bit. When it is 1, the driver enable equals the fabric product-term enable for that pin.
- R7: The fabric pin inputs equal the pin levels in the same cycle, with no register stage.
- R8: The memory-disable output is 1 exactly when the chip-select-input function is enabled and pin B is high.
- R9: The fabric clock output follows pin A when the clock-input function is enabled and is 0 otherwise.
- R10: The per-pin fast-slew outputs equal the slew configuration bits.
- R11: A write to address 0 or 3, a write with the write strobe low, or a write to the other register address leaves the output data and direction registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 pin levels, 1 output data, 2 direction, 3 unused |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| cfg_src | input | 2 | Per-pin output source: 0 data register, 1 fabric chip select |
| cfg_oe_src | input | 2 | Per-pin enable source: 0 direction bit, 1 product term |
| cfg_csi_en | input | 1 | Enables the chip-select input function on pin B |
| cfg_clk_en | input | 1 | Enables the clock-input function on pin A |
| cfg_slew | input | 2 | Per-pin fast-slew configuration |
| fab_ecs | input | 2 | Fabric chip-select strobes, index 0 pin A, 1 pin B |
| fab_pt_oe | input | 2 | Fabric product-term output enables |
| pin_in | input | 2 | Pad input levels, index 0 pin A, 1 pin B |
| pin_out | output | 2 | Pad output values |
| pin_oe | output | 2 | Pad driver enables |
| pin_slew_fast | output | 2 | Pad fast-slew controls |
| fab_pin_in | output | 2 | Pin levels passed to the fabric |
| fab_clk | output | 1 | Clock to the fabric flip-flops and the power-down counter |
| mem_disable | output | 1 | Disables flash, SRAM and control-register space |

## Verification
Every cycle, the assertions check that register writes land and that non-matching writes leave storage untouched. They also check that the reserved read bits stay zero, that each output and enable multiplexer follows its selected source, and that the memory-disable and fabric-clock outputs follow their qualifying configuration bits. Only the bench scenarios show the reset values and the exact bit placement in read-back for concrete write patterns. They also show that the fabric sees pin changes within the same cycle, and that the unused address reads zero.

// File: rtl/dpio_pkg.sv
package dpio_pkg;

    localparam int REG_W   = 8;
    localparam int NPIN    = 2;
    localparam int PIN_LSB = 1;
    localparam int ADDR_W  = 2;
    localparam int PIN_CLK = 0;
    localparam int PIN_CSI = 1;

    localparam logic [REG_W-1:0] USED_MASK = ((1 << NPIN) - 1) << PIN_LSB;

    typedef enum logic [ADDR_W-1:0] {
        RA_LEVEL = 2'd0,
        RA_DOUT  = 2'd1,
        RA_DIR   = 2'd2,
        RA_NONE  = 2'd3
    } reg_addr_e;

    typedef enum logic {
        SRC_MCU = 1'b0,
        SRC_ECS = 1'b1
    } out_src_e;

    typedef enum logic {
        OE_FROM_DIR = 1'b0,
        OE_FROM_PT  = 1'b1
    } oe_src_e;

    typedef struct packed {
        logic [NPIN-1:0] dout;
        logic [NPIN-1:0] dir;
    } port_state_t;

    function automatic logic [REG_W-1:0] place_bits(input logic [NPIN-1:0] v);
        logic [REG_W-1:0] r;
        r = '0;
        r[PIN_LSB +: NPIN] = v;
        return r;
    endfunction

    function automatic logic [NPIN-1:0] pick_bits(input logic [REG_W-1:0] w);
        return w[PIN_LSB +: NPIN];
    endfunction

endpackage

// File: rtl/dpio_regs.sv
module dpio_regs
    import dpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output port_state_t       state
);

    reg_addr_e  ra;
    logic       hit_dout;
    logic       hit_dir;

    assign ra       = reg_addr_e'(addr);
    assign hit_dout = we && (ra == RA_DOUT);
    assign hit_dir  = we && (ra == RA_DIR);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= '0;
        end else begin
            if (hit_dout) state.dout <= pick_bits(wdata);
            if (hit_dir)  state.dir  <= pick_bits(wdata);
        end
    end

    AST_DOUT_LOAD: assert property (@(posedge clk) disable iff (rst)
        (we && addr == RA_DOUT) |=> state.dout == pick_bits($past(wdata))); // R2
    AST_DIR_LOAD: assert property (@(posedge clk) disable iff (rst)
        (we && addr == RA_DIR) |=> state.dir == pick_bits($past(wdata))); // R3
    AST_DOUT_KEEP: assert property (@(posedge clk) disable iff (rst)
        !(we && addr == RA_DOUT) |=> $stable(state.dout)); // R11
    AST_DIR_KEEP: assert property (@(posedge clk) disable iff (rst)
        !(we && addr == RA_DIR) |=> $stable(state.dir)); // R11

endmodule

// File: rtl/dpio_pin.sv
module dpio_pin
    import dpio_pkg::*;
(
    input  out_src_e src,
    input  oe_src_e  oe_sel,
    input  logic     dout_bit,
    input  logic     dir_bit,
    input  logic     ecs,
    input  logic     pt_oe,
    output logic     pad_o,
    output logic     pad_oe
);

    always_comb begin
        unique case (src)
            SRC_ECS: pad_o = ecs;
            default: pad_o = dout_bit;
        endcase
    end

    always_comb begin
        unique case (oe_sel)
            OE_FROM_PT: pad_oe = pt_oe;
            default:    pad_oe = dir_bit;
        endcase
    end

endmodule

// File: rtl/dpio_rdmux.sv
module dpio_rdmux
    import dpio_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [NPIN-1:0]   levels,
    input  port_state_t       state,
    output logic [REG_W-1:0]  rdata
);

    always_comb begin
        unique case (reg_addr_e'(addr))
            RA_LEVEL: rdata = place_bits(levels);
            RA_DOUT:  rdata = place_bits(state.dout);
            RA_DIR:   rdata = place_bits(state.dir);
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/dpio_port.sv
module dpio_port
    import dpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [NPIN-1:0]   cfg_src,
    input  logic [NPIN-1:0]   cfg_oe_src,
    input  logic              cfg_csi_en,
    input  logic              cfg_clk_en,
    input  logic [NPIN-1:0]   cfg_slew,
    input  logic [NPIN-1:0]   fab_ecs,
    input  logic [NPIN-1:0]   fab_pt_oe,
    input  logic [NPIN-1:0]   pin_in,
    output logic [NPIN-1:0]   pin_out,
    output logic [NPIN-1:0]   pin_oe,
    output logic [NPIN-1:0]   pin_slew_fast,
    output logic [NPIN-1:0]   fab_pin_in,
    output logic              fab_clk,
    output logic              mem_disable
);

    port_state_t st;

    dpio_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (bus_we),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .state (st)
    );

    dpio_rdmux u_rd (
        .addr   (bus_addr),
        .levels (pin_in),
        .state  (st),
        .rdata  (bus_rdata)
    );

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        dpio_pin u_pin (
            .src      (out_src_e'(cfg_src[i])),
            .oe_sel   (oe_src_e'(cfg_oe_src[i])),
            .dout_bit (st.dout[i]),
            .dir_bit  (st.dir[i]),
            .ecs      (fab_ecs[i]),
            .pt_oe    (fab_pt_oe[i]),
            .pad_o    (pin_out[i]),
            .pad_oe   (pin_oe[i])
        );

        AST_OUT_SRC: assert property (@(posedge clk) disable iff (rst)
            pin_out[i] == (cfg_src[i] ? fab_ecs[i] : st.dout[i])); // R5
        AST_OE_SRC: assert property (@(posedge clk) disable iff (rst)
            pin_oe[i] == (cfg_oe_src[i] ? fab_pt_oe[i] : st.dir[i])); // R6
    end

    assign fab_pin_in    = pin_in;
    assign pin_slew_fast = cfg_slew;
    assign fab_clk       = cfg_clk_en & pin_in[PIN_CLK];
    assign mem_disable   = cfg_csi_en & pin_in[PIN_CSI];

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata & ~USED_MASK) == '0); // R4
    AST_MEMDIS_QUAL: assert property (@(posedge clk) disable iff (rst)
        mem_disable |-> (cfg_csi_en && pin_in[PIN_CSI])); // R8
    AST_CLK_QUAL: assert property (@(posedge clk) disable iff (rst)
        !cfg_clk_en |-> !fab_clk); // R9

endmodule

// File: tb/tb_dpio_port.sv
module tb_dpio_port;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       bus_we;
    logic [1:0] bus_addr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic [1:0] cfg_src, cfg_oe_src, cfg_slew;
    logic       cfg_csi_en, cfg_clk_en;
    logic [1:0] fab_ecs, fab_pt_oe, pin_in;
    logic [1:0] pin_out, pin_oe, pin_slew_fast, fab_pin_in;
    logic       fab_clk, mem_disable;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpio_port dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_src(cfg_src),
        .cfg_oe_src(cfg_oe_src), .cfg_csi_en(cfg_csi_en), .cfg_clk_en(cfg_clk_en),
        .cfg_slew(cfg_slew), .fab_ecs(fab_ecs), .fab_pt_oe(fab_pt_oe),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .pin_slew_fast(pin_slew_fast), .fab_pin_in(fab_pin_in),
        .fab_clk(fab_clk), .mem_disable(mem_disable)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        cfg_oe_src = 2'b00; cfg_src = 2'b00;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd(2'd1, d); chk("R1 dout after reset", d, 8'h00);
        rd(2'd2, d); chk("R1 dir after reset", d, 8'h00);
        chk("R1 pins are inputs", pin_oe, 2'b00);
    endtask

    task automatic t_dout_rw();
        logic [7:0] d;
        wr(2'd1, 8'hFF); rd(2'd1, d); chk("R2 dout all ones", d, 8'h06);
        wr(2'd1, 8'h02); rd(2'd1, d); chk("R2 dout pin A only", d, 8'h02);
        wr(2'd1, 8'hFD); rd(2'd1, d); chk("R2 dout pin B, junk bits", d, 8'h04);
    endtask

    task automatic t_dir_rw();
        logic [7:0] d;
        wr(2'd2, 8'hF9); rd(2'd2, d); chk("R3 dir none", d, 8'h00);
        wr(2'd2, 8'h04); rd(2'd2, d); chk("R3 dir pin B", d, 8'h04);
        wr(2'd2, 8'h06); rd(2'd2, d); chk("R3 dir both", d, 8'h06);
    endtask

    task automatic t_level_read();
        logic [7:0] d;
        for (int v = 0; v < 4; v++) begin
            pin_in = 2'(v);
            rd(2'd0, d); chk("R4 live level read", d, {5'b0, 2'(v), 1'b0});
        end
        rd(2'd3, d); chk("R4 unused address", d, 8'h00);
    endtask

    task automatic t_ignored_write();
        logic [7:0] d;
        wr(2'd1, 8'h02); wr(2'd2, 8'h04);
        wr(2'd0, 8'hFF); wr(2'd3, 8'hFF);
        @(negedge clk); bus_we = 1'b0; bus_addr = 2'd1; bus_wdata = 8'hFF;
        @(negedge clk);
        rd(2'd1, d); chk("R11 dout unchanged", d, 8'h02);
        rd(2'd2, d); chk("R11 dir unchanged", d, 8'h04);
        wr(2'd2, 8'h00); rd(2'd1, d); chk("R11 dir write leaves dout", d, 8'h02);
    endtask

    task automatic t_out_mux();
        wr(2'd1, 8'h02);
        fab_ecs = 2'b10; cfg_src = 2'b00; #1;
        chk("R5 both from data register", pin_out, 2'b01);
        cfg_src = 2'b11; #1;
        chk("R5 both from chip select", pin_out, 2'b10);
        cfg_src = 2'b01; fab_ecs = 2'b00; #1;
        chk("R5 mixed sources", pin_out, 2'b00);
    endtask

    task automatic t_oe_mux();
        wr(2'd2, 8'h04);
        fab_pt_oe = 2'b01; cfg_oe_src = 2'b00; #1;
        chk("R6 enable from direction", pin_oe, 2'b10);
        cfg_oe_src = 2'b11; #1;
        chk("R6 enable from product term", pin_oe, 2'b01);
        cfg_oe_src = 2'b10; #1;
        chk("R6 mixed enable", pin_oe, 2'b00);
        cfg_oe_src = 2'b00;
    endtask

    task automatic t_fabric_in();
        pin_in = 2'b10; #1; chk("R7 fabric input", fab_pin_in, 2'b10);
        pin_in = 2'b01; #1; chk("R7 fabric input follows", fab_pin_in, 2'b01);
    endtask

    task automatic t_csi();
        cfg_csi_en = 1'b0; pin_in = 2'b10; #1; chk("R8 disabled function", mem_disable, 1'b0);
        cfg_csi_en = 1'b1; #1; chk("R8 pin B high", mem_disable, 1'b1);
        pin_in = 2'b01; #1; chk("R8 pin B low", mem_disable, 1'b0);
        cfg_csi_en = 1'b0;
    endtask

    task automatic t_clkin();
        cfg_clk_en = 1'b0; pin_in = 2'b01; #1; chk("R9 clock gated off", fab_clk, 1'b0);
        cfg_clk_en = 1'b1; #1; chk("R9 clock high", fab_clk, 1'b1);
        pin_in = 2'b10; #1; chk("R9 clock low", fab_clk, 1'b0);
    endtask

    task automatic t_slew();
        cfg_slew = 2'b01; #1; chk("R10 slew", pin_slew_fast, 2'b01);
        cfg_slew = 2'b10; #1; chk("R10 slew swap", pin_slew_fast, 2'b10);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bus_we = 1'b0; bus_addr = 2'd0; bus_wdata = 8'h00;
        cfg_src = 2'b00; cfg_oe_src = 2'b00; cfg_csi_en = 1'b0; cfg_clk_en = 1'b0;
        cfg_slew = 2'b00; fab_ecs = 2'b00; fab_pt_oe = 2'b00; pin_in = 2'b00;
        repeat (2) @(negedge clk);
        t_reset();
        t_dout_rw();
        t_dir_rw();
        t_level_read();
        t_ignored_write();
        t_out_mux();
        t_oe_mux();
        t_fabric_in();
        t_csi();
        t_clkin();
        t_slew();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule